// File: doc/BRIEF.md
# Host-to-DSP Word Mailbox with Program Loader

This block joins an 8-bit host processor bus to a 24-bit signal-processor peripheral bus. Each direction has a single-word mailbox guarded by a pair of full/empty flags: one flag is seen by the host and one by the DSP. The host sees a 24-bit word as three byte registers. A word moves across as soon as the sending side has committed it and the receiving side has drained the previous one. The host also owns a control byte whose two flag bits are mirrored to the DSP, a command-vector byte that can raise a command-pending flag on the DSP side, and a plain vector byte.

After reset the block is in loader mode. In this mode every committed host word is sent to a program-memory write port at addresses 0, 1, 2, … instead of entering the mailbox. After the last loader word the block switches to run mode for good, and committed words then go through the mailbox. Both sides share one clock and one synchronous active-high reset. Host reads return data one cycle after a single-cycle read strobe.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, host status (address 4) reads 0x06, command vector (address 6) reads 0x12, vector (address 7) reads 0x0F, control (address 5) reads 0x00, `d_status` is 0x02 and `running` is 0.
- R2: Host data addresses 2, 1 and 0 carry word bits 23:16, 15:8 and 7:0. Writes to addresses 2 and 1 only store the byte. A write to address 0 commits the word built from the stored upper bytes and the new low byte.
- R3: In run mode, a committed host word clears host transmit-empty (status bit 1). Whenever transmit-empty is clear and DSP receive-full (`d_status` bit 0) is clear, the word is copied to `d_rx_data`, receive-full is set and transmit-empty is set again.
- R4: A `d_wr` loads `d_wdata` and clears DSP transmit-empty (`d_status` bit 1). Whenever that flag is clear and host receive-full (status bit 0) is clear, the word is copied to the host receive bytes, DSP transmit-empty is set and host receive-full is set.
- R5: A host read strobe on address 0 clears host receive-full, and a waiting DSP word then moves across in the same cycle.
- R6: A `d_rd` strobe clears DSP receive-full, and a waiting host word then moves across in the same cycle. Receive-full never clears in any other way.
- R7: Host status bit 2 (ready) equals transmit-empty AND NOT DSP receive-full.
- R8: A control write stores the value AND 0xFB, and copies its bits 3 and 4 to `d_status` bits 3 and 4.
- R9: A command-vector write stores the value AND 0x9F. If bit 7 of the written value is 1, `d_status` bit 2 is set, and it stays set until reset.
- R10: Writes to the status address 4 and the spare address 3 change nothing. Address 3 always reads 0x00.
- R11: In loader mode, each write to address 0 pulses `boot_we` in the next cycle with `boot_addr` equal to the number of earlier loader words and `boot_data` equal to the committed word. The mailbox flags do not change.
- R12: The loader word numbered BOOT_WORDS-1 sets `running`, which then stays set. After that, no loader writes are issued.
- R13: `h_rdata` changes only in the cycle after an `h_rd` strobe, and then holds the value of the addressed register as it was when the strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host byte register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| d_rd | input | 1 | DSP read strobe for the receive word |
| d_wr | input | 1 | DSP write strobe for the transmit word |
| d_wdata | input | 24 | DSP transmit word |
| d_rx_data | output | 24 | DSP receive word |
| d_status | output | 8 | DSP status: bit0 receive-full, bit1 transmit-empty, bit2 command pending, bit3/4 host flags |
| running | output | 1 | High once the loader has finished |
| boot_we | output | 1 | Program memory write enable |
| boot_addr | output | 9 | Program memory write address |
| boot_data | output | 24 | Program memory write data |

## Verification
The checker watches several rules on every cycle. The two full/empty flags on the DSP side only drop on that side's own strobes. The command flag is sticky. Writes to the ignored addresses leave `d_status` as it was. Loader pulses stop once the block runs, and the switch to run mode lines up with the final loader address. The ready bit is checked against the empty flag and DSP receive-full each time status is read back. Only the bench scenarios can show the data-dependent behaviour: the byte order within words, the chained transfers set off by a drain while a word is waiting, the read-back masks, and the exact sequence of loader addresses and data across the full load.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  localparam int HP_AW    = 3;
  localparam int HP_LANES = 3;

  // host byte map
  localparam logic [HP_AW-1:0] A_DLO   = 3'd0;
  localparam logic [HP_AW-1:0] A_DMID  = 3'd1;
  localparam logic [HP_AW-1:0] A_DHI   = 3'd2;
  localparam logic [HP_AW-1:0] A_SPARE = 3'd3;
  localparam logic [HP_AW-1:0] A_STAT  = 3'd4;
  localparam logic [HP_AW-1:0] A_CTRL  = 3'd5;
  localparam logic [HP_AW-1:0] A_CVEC  = 3'd6;
  localparam logic [HP_AW-1:0] A_IVEC  = 3'd7;

  // host status bit positions
  localparam int HS_RXFULL  = 0;
  localparam int HS_TXEMPTY = 1;
  localparam int HS_READY   = 2;

  // DSP status bit positions
  localparam int DS_INFULL   = 0;
  localparam int DS_OUTEMPTY = 1;
  localparam int DS_CMD      = 2;
  localparam int DS_HF0      = 3;
  localparam int DS_HF1      = 4;

  // control byte flag positions (same as DSP side)
  localparam int CT_HF0 = 3;
  localparam int CT_HF1 = 4;

  localparam logic [7:0] CTRL_KEEP = 8'hFB;
  localparam logic [7:0] CVEC_KEEP = 8'h9F;
  localparam logic [7:0] CVEC_INIT = 8'h12;
  localparam logic [7:0] IVEC_INIT = 8'h0F;
  localparam int         CVEC_GO   = 7;

  typedef struct packed {
    logic rx_full;    // host receive bytes hold an unread word
    logic tx_empty;   // host transmit bytes may be overwritten
    logic in_full;    // DSP receive word not yet taken
    logic out_empty;  // DSP transmit word already moved
  } hpb_flags_t;

endpackage

// File: rtl/hpb_tx_lanes.sv
module hpb_tx_lanes
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = BYTE_W * HP_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [HP_AW-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] word_o
);

  logic [BYTE_W-1:0] lane_q [HP_LANES];

  for (genvar i = 0; i < HP_LANES; i++) begin : g_lane
    logic hit;
    assign hit = wr && (addr == HP_AW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[i] <= '0;
      end else if (hit) begin
        lane_q[i] <= wdata;
      end
    end

    // bypass so a low-byte commit sees its own byte
    assign word_o[i*BYTE_W +: BYTE_W] = hit ? wdata : lane_q[i];
  end

endmodule

// File: rtl/hpb_handshake.sv
module hpb_handshake
  import hpb_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_commit,
  input  logic              host_take,
  input  logic              dsp_take,
  input  logic              dsp_give,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [WORD_W-1:0] dsp_word,
  output hpb_flags_t        flags_o,
  output logic [WORD_W-1:0] host_rx_word,
  output logic [WORD_W-1:0] dsp_rx_word
);

  hpb_flags_t        f_q, f_n;
  logic [WORD_W-1:0] hrx_q, hrx_n;
  logic [WORD_W-1:0] drx_q, drx_n;
  logic [WORD_W-1:0] dtx_q, dtx_n;

  always_comb begin
    f_n   = f_q;
    hrx_n = hrx_q;
    drx_n = drx_q;
    dtx_n = dtx_q;

    // first the events of this cycle
    if (host_commit) f_n.tx_empty = 1'b0;
    if (host_take)   f_n.rx_full  = 1'b0;
    if (dsp_take)    f_n.in_full  = 1'b0;
    if (dsp_give) begin
      f_n.out_empty = 1'b0;
      dtx_n         = dsp_word;
    end

    // then both transfer conditions on the updated flags
    if (!f_n.tx_empty && !f_n.in_full) begin
      drx_n        = tx_word;
      f_n.in_full  = 1'b1;
      f_n.tx_empty = 1'b1;
    end
    if (!f_n.rx_full && !f_n.out_empty) begin
      hrx_n         = dtx_n;
      f_n.out_empty = 1'b1;
      f_n.rx_full   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q   <= '{rx_full: 1'b0, tx_empty: 1'b1, in_full: 1'b0, out_empty: 1'b1};
      hrx_q <= '0;
      drx_q <= '0;
      dtx_q <= '0;
    end else begin
      f_q   <= f_n;
      hrx_q <= hrx_n;
      drx_q <= drx_n;
      dtx_q <= dtx_n;
    end
  end

  assign flags_o      = f_q;
  assign host_rx_word = hrx_q;
  assign dsp_rx_word  = drx_q;

endmodule

// File: rtl/hpb_loader.sv
module hpb_loader #(
  parameter int WORD_W     = 24,
  parameter int BOOT_WORDS = 512,
  parameter int BOOT_AW    = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [WORD_W-1:0]  word,
  output logic               running,
  output logic               we,
  output logic [BOOT_AW-1:0] addr,
  output logic [WORD_W-1:0]  data
);

  localparam logic [BOOT_AW-1:0] LAST = BOOT_AW'(BOOT_WORDS - 1);

  logic [BOOT_AW-1:0] cnt_q;
  logic               take;

  assign take = commit && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      running <= 1'b0;
      we      <= 1'b0;
      addr    <= '0;
      data    <= '0;
    end else begin
      we <= take;
      if (take) begin
        addr  <= cnt_q;
        data  <= word;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) running <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hpb_host_regs.sv
module hpb_host_regs
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = BYTE_W * HP_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [HP_AW-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] rx_word,
  input  hpb_flags_t        flags,
  output logic [BYTE_W-1:0] rdata,
  output logic [1:0]        hf,
  output logic              cmd_pending
);

  logic [BYTE_W-1:0] ctrl_q, cvec_q, ivec_q, stat_b, rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      cvec_q      <= BYTE_W'(CVEC_INIT);
      ivec_q      <= BYTE_W'(IVEC_INIT);
      cmd_pending <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_CTRL: ctrl_q <= wdata & BYTE_W'(CTRL_KEEP);
        A_CVEC: begin
          cvec_q <= wdata & BYTE_W'(CVEC_KEEP);
          if (wdata[CVEC_GO]) cmd_pending <= 1'b1;
        end
        A_IVEC: ivec_q <= wdata;
        default: ;
      endcase
    end
  end

  assign hf = {ctrl_q[CT_HF1], ctrl_q[CT_HF0]};

  always_comb begin
    stat_b             = '0;
    stat_b[HS_RXFULL]  = flags.rx_full;
    stat_b[HS_TXEMPTY] = flags.tx_empty;
    stat_b[HS_READY]   = flags.tx_empty & ~flags.in_full;
  end

  always_comb begin
    case (addr)
      A_DLO:   rd_mux = rx_word[0*BYTE_W +: BYTE_W];
      A_DMID:  rd_mux = rx_word[1*BYTE_W +: BYTE_W];
      A_DHI:   rd_mux = rx_word[2*BYTE_W +: BYTE_W];
      A_STAT:  rd_mux = stat_b;
      A_CTRL:  rd_mux = ctrl_q;
      A_CVEC:  rd_mux = cvec_q;
      A_IVEC:  rd_mux = ivec_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hpb_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_W     = BYTE_W * HP_LANES,
  parameter int BOOT_WORDS = 512,
  parameter int BOOT_AW    = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HP_AW-1:0]   h_addr,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [BYTE_W-1:0]  h_wdata,
  output logic [BYTE_W-1:0]  h_rdata,
  input  logic               d_rd,
  input  logic               d_wr,
  input  logic [WORD_W-1:0]  d_wdata,
  output logic [WORD_W-1:0]  d_rx_data,
  output logic [BYTE_W-1:0]  d_status,
  output logic               running,
  output logic               boot_we,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic [WORD_W-1:0]  boot_data
);

  logic [WORD_W-1:0] tx_word, host_rx_word;
  logic              lo_write, lo_read;
  hpb_flags_t        flags;
  logic [1:0]        hf;
  logic              cmd_pending;

  assign lo_write = h_wr && (h_addr == A_DLO);
  assign lo_read  = h_rd && (h_addr == A_DLO);

  hpb_tx_lanes #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_lanes (
    .clk    (clk),
    .rst    (rst),
    .wr     (h_wr),
    .addr   (h_addr),
    .wdata  (h_wdata),
    .word_o (tx_word)
  );

  hpb_loader #(.WORD_W(WORD_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_AW(BOOT_AW)) u_loader (
    .clk     (clk),
    .rst     (rst),
    .commit  (lo_write),
    .word    (tx_word),
    .running (running),
    .we      (boot_we),
    .addr    (boot_addr),
    .data    (boot_data)
  );

  hpb_handshake #(.WORD_W(WORD_W)) u_hs (
    .clk          (clk),
    .rst          (rst),
    .host_commit  (lo_write && running),
    .host_take    (lo_read),
    .dsp_take     (d_rd),
    .dsp_give     (d_wr),
    .tx_word      (tx_word),
    .dsp_word     (d_wdata),
    .flags_o      (flags),
    .host_rx_word (host_rx_word),
    .dsp_rx_word  (d_rx_data)
  );

  hpb_host_regs #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr          (h_wr),
    .rd          (h_rd),
    .addr        (h_addr),
    .wdata       (h_wdata),
    .rx_word     (host_rx_word),
    .flags       (flags),
    .rdata       (h_rdata),
    .hf          (hf),
    .cmd_pending (cmd_pending)
  );

  always_comb begin
    d_status              = '0;
    d_status[DS_INFULL]   = flags.in_full;
    d_status[DS_OUTEMPTY] = flags.out_empty;
    d_status[DS_CMD]      = cmd_pending;
    d_status[DS_HF0]      = hf[0];
    d_status[DS_HF1]      = hf[1];
  end

endmodule

// File: rtl/hpb_checker.sv
module hpb_checker
  import hpb_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int BOOT_WORDS = 512,
  parameter int BOOT_AW    = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [HP_AW-1:0]   h_addr,
  input logic               h_wr,
  input logic               h_rd,
  input logic [BYTE_W-1:0]  h_rdata,
  input logic               d_rd,
  input logic               d_wr,
  input logic [BYTE_W-1:0]  d_status,
  input logic               running,
  input logic               boot_we,
  input logic [BOOT_AW-1:0] boot_addr
);

  // R6: DSP receive-full only drops on a DSP read
  p_infull_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (d_status[DS_INFULL] && !d_rd) |=> d_status[DS_INFULL]);

  // R4: DSP transmit-empty only drops on a DSP write
  p_outempty_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (d_status[DS_OUTEMPTY] && !d_wr) |=> d_status[DS_OUTEMPTY]);

  // R9: command pending is sticky
  p_cmd_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    d_status[DS_CMD] |=> d_status[DS_CMD]);

  // R8: host flags on DSP side move only on a control write
  p_hf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(h_wr && h_addr == A_CTRL) |=> $stable(d_status[DS_HF1:DS_HF0]));

  // R10: ignored addresses leave DSP status untouched
  p_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (h_wr && (h_addr == A_STAT || h_addr == A_SPARE) && !d_rd && !d_wr)
    |=> $stable(d_status));

  // R7: ready bit read back matches empty flag and DSP receive-full
  p_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (h_rd && h_addr == A_STAT) |=>
    (h_rdata[HS_READY] == (h_rdata[HS_TXEMPTY] & ~$past(d_status[DS_INFULL]))));

  // R13: read data only moves after a strobe
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(h_rdata));

  // R12: run mode is permanent and no loader writes follow
  p_run_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    running |=> (running && !boot_we));

  // R12: entering run mode coincides with the final loader address
  p_run_entry_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> (boot_we && boot_addr == BOOT_AW'(BOOT_WORDS - 1)));

  // R11: loader-mode commits produce a program write
  p_boot_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (!running && h_wr && h_addr == A_DLO) |=> boot_we);

endmodule

bind hostport_bridge hpb_checker #(
  .BYTE_W(BYTE_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_AW(BOOT_AW)
) u_chk (.*);

// File: tb/hostport_bridge_bench.sv
module hostport_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NBOOT      = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        d_rd = 1'b0, d_wr = 1'b0;
  logic [23:0] d_wdata = '0;
  logic [23:0] d_rx_data;
  logic [7:0]  d_status;
  logic        running, boot_we;
  logic [8:0]  boot_addr;
  logic [23:0] boot_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hostport_bridge u_hostport_bridge (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] v);
    @(negedge clk); h_addr = a; h_wdata = v; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; v = h_rdata;
  endtask

  task automatic hword(logic [23:0] w);
    hwrite(3'd2, w[23:16]); hwrite(3'd1, w[15:8]); hwrite(3'd0, w[7:0]);
  endtask

  task automatic dwrite(logic [23:0] w);
    @(negedge clk); d_wdata = w; d_wr = 1'b1;
    @(negedge clk); d_wr = 1'b0;
  endtask

  task automatic dread(output logic [23:0] w);
    @(negedge clk); w = d_rx_data; d_rd = 1'b1;
    @(negedge clk); d_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  b, b2;
    logic [23:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 dstat", {24'd0, d_status}, 32'h02);
    check("R1 running", {31'd0, running}, 0);
    hread(3'd4, b); check("R1 hstat", {24'd0, b}, 32'h06);
    hread(3'd6, b); check("R1 cvec", {24'd0, b}, 32'h12);
    hread(3'd7, b); check("R1 ivec", {24'd0, b}, 32'h0F);
    hread(3'd5, b); check("R1 ctrl", {24'd0, b}, 32'h00);

    // R11/R12 loader
    for (int i = 0; i < NBOOT; i++) begin
      logic [23:0] bw;
      bw = 24'((i * 32'h00010307 + 32'h5A) & 32'hFFFFFF);
      hword(bw);
      check("R11 we", {31'd0, boot_we}, 1);
      check("R11 addr", {23'd0, boot_addr}, i);
      check("R11 data", {8'd0, boot_data}, {8'd0, bw});
      check("R12 running", {31'd0, running}, (i == NBOOT-1) ? 1 : 0);
    end
    check("R11 dstat", {24'd0, d_status}, 32'h02);
    hread(3'd4, b); check("R11 hstat", {24'd0, b}, 32'h06);

    // R3/R2 host to DSP, R12 run-mode commit
    hword(24'hA1B2C3);
    check("R12 no boot", {31'd0, boot_we}, 0);
    check("R3 dstat", {24'd0, d_status}, 32'h03);
    check("R2 drx", {8'd0, d_rx_data}, 32'hA1B2C3);
    hread(3'd4, b); check("R7 hstat full", {24'd0, b}, 32'h02);
    hword(24'h445566);
    hread(3'd4, b); check("R3 wait hstat", {24'd0, b}, 32'h00);
    check("R3 drx held", {8'd0, d_rx_data}, 32'hA1B2C3);
    dread(w); check("R6 take1", {8'd0, w}, 32'hA1B2C3);
    check("R6 chained", {8'd0, d_rx_data}, 32'h445566);
    check("R6 infull", {31'd0, d_status[0]}, 1);
    hread(3'd4, b); check("R6 hstat", {24'd0, b}, 32'h02);
    dread(w);
    check("R6 cleared", {31'd0, d_status[0]}, 0);
    hread(3'd4, b); check("R7 ready", {24'd0, b}, 32'h06);

    // R4/R5 DSP to host
    dwrite(24'h123456);
    check("R4 outempty", {31'd0, d_status[1]}, 1);
    hread(3'd4, b); check("R4 hstat", {24'd0, b}, 32'h07);
    hread(3'd2, b); check("R2 hi", {24'd0, b}, 32'h12);
    hread(3'd1, b); check("R2 mid", {24'd0, b}, 32'h34);
    hread(3'd4, b); check("R5 still full", {24'd0, b}, 32'h07);
    dwrite(24'h9ABCDE);
    check("R4 blocked", {31'd0, d_status[1]}, 0);
    hread(3'd0, b); check("R2 lo", {24'd0, b}, 32'h56);
    check("R5 chained", {31'd0, d_status[1]}, 1);
    hread(3'd2, b); check("R5 new hi", {24'd0, b}, 32'h9A);
    hread(3'd0, b); check("R5 new lo", {24'd0, b}, 32'hDE);
    hread(3'd4, b); check("R5 drained", {24'd0, b}, 32'h06);

    // sweep of word patterns both ways
    for (int k = 0; k < 32; k++) begin
      logic [23:0] hw, dw, got;
      logic [7:0]  r;
      hw = 24'((k * 32'h0B1D3) ^ 32'h5A5A5A);
      dw = ~hw ^ 24'(k);
      hword(hw);
      dread(got); check("R3 sweep", {8'd0, got}, {8'd0, hw});
      dwrite(dw);
      hread(3'd2, r); check("R4 sweep hi", {24'd0, r}, {24'd0, dw[23:16]});
      hread(3'd1, r); check("R4 sweep mid", {24'd0, r}, {24'd0, dw[15:8]});
      hread(3'd0, r); check("R4 sweep lo", {24'd0, r}, {24'd0, dw[7:0]});
    end

    // R13 latency
    @(negedge clk); h_addr = 3'd7; h_rd = 1'b1;
    b2 = h_rdata;
    @(negedge clk); h_rd = 1'b0; b = h_rdata;
    check("R13 strobe", {24'd0, b}, 32'h0F);
    repeat (3) @(negedge clk);
    check("R13 hold", {24'd0, h_rdata}, 32'h0F);
    check("R13 before", {31'd0, (b2 == 8'h0F)}, 0);

    // R8 control
    hwrite(3'd5, 8'hFF);
    hread(3'd5, b); check("R8 mask", {24'd0, b}, 32'hFB);
    check("R8 hf both", {30'd0, d_status[4:3]}, 3);
    hwrite(3'd5, 8'h08);
    check("R8 hf0", {30'd0, d_status[4:3]}, 1);
    hwrite(3'd5, 8'h04);
    hread(3'd5, b); check("R8 bit2", {24'd0, b}, 32'h00);
    check("R8 hf none", {30'd0, d_status[4:3]}, 0);

    // R9 command vector
    hwrite(3'd6, 8'h7F);
    hread(3'd6, b); check("R9 mask", {24'd0, b}, 32'h1F);
    check("R9 no cmd", {31'd0, d_status[2]}, 0);
    hwrite(3'd6, 8'hE5);
    hread(3'd6, b); check("R9 mask hi", {24'd0, b}, 32'h85);
    check("R9 cmd", {31'd0, d_status[2]}, 1);
    hwrite(3'd6, 8'h01);
    check("R9 sticky", {31'd0, d_status[2]}, 1);
    hwrite(3'd7, 8'h3C);
    hread(3'd7, b); check("R1 ivec write", {24'd0, b}, 32'h3C);

    // R10 ignored writes
    hwrite(3'd4, 8'hFF);
    hwrite(3'd3, 8'hAA);
    hread(3'd4, b); check("R10 hstat", {24'd0, b}, 32'h06);
    hread(3'd3, b); check("R10 spare", {24'd0, b}, 32'h00);
    check("R10 dstat", {24'd0, d_status}, 32'h06);

    done = 1'b1;
    finish_run();
  end

endmodule